// File: doc/BRIEF.md
# Floating-Point Fraction-Bit Rounder

This block takes one single-precision value and rounds it to a multiple of 2^-M, where M is a small unsigned count of binary fraction bits carried in the upper nibble of an 8-bit control byte. With M at zero it is a plain round-to-integer operation. The result is exactly what would come from scaling the input up by 2^M, rounding to an integer, and scaling back down. No intermediate step can overflow or underflow, so subnormal inputs and values close to a binade boundary are handled exactly.

The low nibble of the control byte chooses how the rounding is done. Two bits give the rounding direction. One bit selects the rounding mode supplied on a separate input, which stands in for a chip-wide rounding-control register. The last bit suppresses the inexact report.

Zeros, infinities and NaNs are handled as special cases. The datapath is combinational. The result and the inexact flag are registered once and marked by an output valid, one cycle after the input valid.

The output side is a two-state machine:
- OUT_IDLE: nothing is presented.
- OUT_LOADED: a result is on the output.

Every clock edge with in_valid high moves the machine to OUT_LOADED (the transition "capture"). Every edge with in_valid low moves it to OUT_IDLE (the transition "drain"). Reset puts the machine in OUT_IDLE.

Top module: `fpr_round_frac`

## Requirements
- R1: For a finite nonzero input, the result is the input rounded to a multiple of 2^-M, with M = in_ctrl[7:4]. The direction comes from in_ctrl[1:0]: 00 is nearest with ties to even, 01 is toward negative infinity, 10 is toward positive infinity, 11 is toward zero.
- R2: In nearest mode, an input lying exactly halfway between two multiples of 2^-M rounds to the multiple whose last kept bit is zero.
- R3: When in_ctrl[2] is 1, the direction is taken from cur_mode (same encoding as R1), and in_ctrl[1:0] has no effect.
- R4: When in_ctrl[3] is 1, out_inexact is 0 whatever bits are discarded.
- R5: When in_ctrl[3] is 0, out_inexact is 1 exactly when the rounded result differs from a finite input.
- R6: An input with no set bit below 2^-M is returned unchanged with out_inexact 0.
- R7: Zero and infinity inputs are returned unchanged with out_inexact 0. The sign bit of every non-NaN result equals the input sign, including results that round to zero.
- R8: A NaN input yields the same sign and payload with the quiet bit (bit 22) set, and out_inexact 0.
- R9: Subnormal inputs round to zero or to 2^-M without underflow. A carry out of the kept bits produces the next power of two.
- R10: out_valid is 0 after reset. It is 1 in the cycle after in_valid is 1 and 0 in the cycle after in_valid is 0. out_value and out_inexact belong to the input of that previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input operand valid |
| in_value | input | 32 | Single-precision operand |
| in_ctrl | input | 8 | [7:4] fraction-bit count M, [3] suppress inexact, [2] use cur_mode, [1:0] direction |
| cur_mode | input | 2 | Externally held rounding direction, same encoding as in_ctrl[1:0] |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_value | output | 32 | Rounded result |
| out_inexact | output | 1 | Set when bits were discarded and not suppressed |

## Verification
The bench builds the block with its default parameters: an 8-bit exponent, a 23-bit fraction and a 4-bit count field. This makes the full M range of 0 to 15 reachable.

With those values the bench can reach three key corners:
- the smallest subnormal rounded up to 2^-15;
- an all-ones significand carrying into the next binade at M = 15;
- a halfway tie at the largest float that still has a fraction bit.

Results stream back to back, so the scoreboard also covers capture and drain transitions on consecutive cycles.

// File: rtl/fpr_pkg.sv
package fpr_pkg;

    typedef enum logic [1:0] {
        RD_NEAREST_EVEN = 2'b00,
        RD_NEG_INF      = 2'b01,
        RD_POS_INF      = 2'b10,
        RD_TO_ZERO      = 2'b11
    } rdir_e;

    typedef enum logic [1:0] {
        CLS_ZERO,
        CLS_FINITE,
        CLS_INF,
        CLS_NAN
    } fcls_e;

    typedef enum logic {
        OUT_IDLE,
        OUT_LOADED
    } ostate_e;

    // Decide whether the kept magnitude must be bumped by one unit.
    function automatic logic round_bump(input rdir_e dir, input logic sign,
                                        input logic lsb, input logic guard,
                                        input logic sticky);
        logic bump;
        unique case (dir)
            RD_NEAREST_EVEN: bump = guard & (sticky | lsb);
            RD_NEG_INF:      bump = (guard | sticky) & sign;
            RD_POS_INF:      bump = (guard | sticky) & ~sign;
            RD_TO_ZERO:      bump = 1'b0;
        endcase
        return bump;
    endfunction

endpackage

// File: rtl/fpr_unpack.sv
module fpr_unpack
    import fpr_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [EXP_W+MAN_W:0] value,
    output logic                 sign,
    output logic [EXP_W-1:0]     exp_eff,
    output logic [MAN_W:0]       sig,
    output fcls_e                cls
);
    logic [EXP_W-1:0] raw_exp;
    logic [MAN_W-1:0] raw_frac;
    logic             exp_max;
    logic             exp_min;

    assign sign     = value[EXP_W+MAN_W];
    assign raw_exp  = value[EXP_W+MAN_W-1:MAN_W];
    assign raw_frac = value[MAN_W-1:0];
    assign exp_max  = &raw_exp;
    assign exp_min  = ~|raw_exp;

    always_comb begin
        if (exp_max) begin
            cls = (|raw_frac) ? CLS_NAN : CLS_INF;
        end else if (exp_min && !(|raw_frac)) begin
            cls = CLS_ZERO;
        end else begin
            cls = CLS_FINITE;
        end
    end

    // Subnormals share the scale of the lowest normal binade, hidden bit clear.
    assign exp_eff = exp_min ? EXP_W'(1) : raw_exp;
    assign sig     = {~exp_min, raw_frac};

endmodule

// File: rtl/fpr_align.sv
module fpr_align
    import fpr_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    parameter int SCL_W = 4
) (
    input  logic [EXP_W-1:0] exp_eff,
    input  logic [MAN_W:0]   sig,
    input  logic [SCL_W-1:0] m_cnt,
    input  logic             sign,
    input  rdir_e            dir,
    output logic [MAN_W+1:0] q_mag,
    output logic             lost,
    output logic             exact
);
    localparam int SIG_W = MAN_W + 1;
    localparam int BIAS  = (1 << (EXP_W - 1)) - 1;
    localparam int THR   = BIAS + MAN_W;
    localparam int MAXSH = SIG_W + 1;
    localparam int SH_W  = $clog2(MAXSH + 1);
    localparam int EXT_W = SIG_W + MAXSH;

    int               diff;
    logic [SH_W-1:0]  shamt;
    logic [EXT_W-1:0] ext;
    logic [SIG_W-1:0] kept;
    logic             guard;
    logic             sticky;
    logic             bump;

    always_comb begin
        // Number of significand bits that fall below the 2^-M grid.
        diff  = THR - int'(m_cnt) - int'(exp_eff);
        exact = (diff <= 0);
        if (diff >= MAXSH) begin
            shamt = SH_W'(MAXSH);
        end else if (diff < 0) begin
            shamt = '0;
        end else begin
            shamt = SH_W'(diff);
        end
        ext    = {sig, {MAXSH{1'b0}}} >> shamt;
        kept   = ext[EXT_W-1:MAXSH];
        guard  = ext[MAXSH-1];
        sticky = |ext[MAXSH-2:0];
        bump   = round_bump(dir, sign, kept[0], guard, sticky);
        q_mag  = {1'b0, kept} + {{SIG_W{1'b0}}, bump};
        lost   = guard | sticky;
    end

endmodule

// File: rtl/fpr_pack.sv
module fpr_pack #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    parameter int SCL_W = 4
) (
    input  logic                 sign,
    input  logic [MAN_W+1:0]     q_mag,
    input  logic [SCL_W-1:0]     m_cnt,
    output logic [EXP_W+MAN_W:0] packed_val
);
    localparam int SIG_W = MAN_W + 1;
    localparam int BIAS  = (1 << (EXP_W - 1)) - 1;
    localparam int LD_W  = $clog2(SIG_W + 1);

    logic [LD_W-1:0]  lead;
    logic [SIG_W:0]   norm;
    logic [EXP_W-1:0] exp_b;

    always_comb begin
        lead = '0;
        for (int i = 0; i <= SIG_W; i++) begin
            if (q_mag[i]) begin
                lead = LD_W'(i);
            end
        end
        // Move the leading one to the top position, then drop it.
        norm  = q_mag << (LD_W'(SIG_W) - lead);
        exp_b = EXP_W'(int'(lead) - int'(m_cnt) + BIAS);
        if (q_mag == '0) begin
            packed_val = {sign, {(EXP_W + MAN_W){1'b0}}};
        end else begin
            packed_val = {sign, exp_b, norm[SIG_W-1:1]};
        end
    end

endmodule

// File: rtl/fpr_round_frac.sv
module fpr_round_frac
    import fpr_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    parameter int SCL_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [EXP_W+MAN_W:0]     in_value,
    input  logic [SCL_W+3:0]         in_ctrl,
    input  logic [1:0]               cur_mode,
    output logic                     out_valid,
    output logic [EXP_W+MAN_W:0]     out_value,
    output logic                     out_inexact
);
    localparam int W      = 1 + EXP_W + MAN_W;
    localparam int CTRL_W = SCL_W + 4;

    // Control decode
    logic [SCL_W-1:0] m_cnt;
    logic             suppress;
    rdir_e            dir;

    assign m_cnt    = in_ctrl[CTRL_W-1:4];
    assign suppress = in_ctrl[3];
    assign dir      = in_ctrl[2] ? rdir_e'(cur_mode) : rdir_e'(in_ctrl[1:0]);

    // Datapath
    logic             u_sign;
    logic [EXP_W-1:0] u_exp;
    logic [MAN_W:0]   u_sig;
    fcls_e            u_cls;
    logic [MAN_W+1:0] a_q;
    logic             a_lost;
    logic             a_exact;
    logic [W-1:0]     p_val;
    logic [W-1:0]     res_val;
    logic             res_inx;

    fpr_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_unpack (
        .value   (in_value),
        .sign    (u_sign),
        .exp_eff (u_exp),
        .sig     (u_sig),
        .cls     (u_cls)
    );

    fpr_align #(.EXP_W(EXP_W), .MAN_W(MAN_W), .SCL_W(SCL_W)) u_align (
        .exp_eff (u_exp),
        .sig     (u_sig),
        .m_cnt   (m_cnt),
        .sign    (u_sign),
        .dir     (dir),
        .q_mag   (a_q),
        .lost    (a_lost),
        .exact   (a_exact)
    );

    fpr_pack #(.EXP_W(EXP_W), .MAN_W(MAN_W), .SCL_W(SCL_W)) u_pack (
        .sign       (u_sign),
        .q_mag      (a_q),
        .m_cnt      (m_cnt),
        .packed_val (p_val)
    );

    always_comb begin
        res_val = in_value;
        res_inx = 1'b0;
        unique case (u_cls)
            CLS_NAN: begin
                res_val = {u_sign, {EXP_W{1'b1}}, 1'b1, in_value[MAN_W-2:0]};
            end
            CLS_INF, CLS_ZERO: begin
                res_val = in_value;
            end
            CLS_FINITE: begin
                if (!a_exact) begin
                    res_val = p_val;
                    res_inx = a_lost & ~suppress;
                end
            end
        endcase
    end

    // Output state machine: state register
    ostate_e state_q;
    ostate_e state_d;

    always_comb begin
        unique case (state_q)
            OUT_IDLE:   state_d = in_valid ? OUT_LOADED : OUT_IDLE;
            OUT_LOADED: state_d = in_valid ? OUT_LOADED : OUT_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OUT_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_value   <= '0;
            out_inexact <= 1'b0;
        end else if (in_valid) begin
            out_value   <= res_val;
            out_inexact <= res_inx;
        end
    end

    assign out_valid = (state_q == OUT_LOADED);

    logic in_is_nan;
    assign in_is_nan = (u_cls == CLS_NAN);

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R10
    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R10
    AST_SUPPRESS_LOW: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && in_ctrl[3]) |=> !out_inexact); // R4
    AST_NAN_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && in_is_nan) |=> (out_value[MAN_W-1] && !out_inexact)); // R8
    AST_SIGN_KEPT: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && !in_is_nan) |=> (out_value[W-1] == $past(in_value[W-1]))); // R7
    AST_TOP_EXP_EXACT: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && (&out_value[W-2:MAN_W])) |-> !out_inexact); // R8

endmodule

// File: tb/fpr_round_frac_test.sv
module fpr_round_frac_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_value = '0;
    logic [7:0]  in_ctrl = '0;
    logic [1:0]  cur_mode = '0;
    logic        out_valid;
    logic [31:0] out_value;
    logic        out_inexact;

    int n_tests = 0;
    int n_fail = 0;
    logic        monitor_on = 1'b0;

    logic [31:0] exp_val_q[$];
    logic        exp_inx_q[$];
    string       exp_tag_q[$];

    fpr_round_frac uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_value    (in_value),
        .in_ctrl     (in_ctrl),
        .cur_mode    (cur_mode),
        .out_valid   (out_valid),
        .out_value   (out_value),
        .out_inexact (out_inexact)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Driver: one operand per cycle, expectation pushed to the scoreboard.
    task automatic drive(input logic [31:0] v, input logic [7:0] c, input logic [1:0] md,
                         input logic [31:0] ev, input logic ei, input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        in_value = v;
        in_ctrl  = c;
        cur_mode = md;
        exp_val_q.push_back(ev);
        exp_inx_q.push_back(ei);
        exp_tag_q.push_back(tag);
    endtask

    task automatic idle_cycle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Monitor: pops and compares whenever a result is presented.
    always @(negedge clk) begin
        if (monitor_on && rst_n && out_valid) begin
            n_tests++;
            if (exp_val_q.size() == 0) begin
                n_fail++;
                $display("FAIL R10: unexpected result %h, expected no output", out_value);
            end else begin
                logic [31:0] ev;
                logic        ei;
                string       tg;
                ev = exp_val_q.pop_front();
                ei = exp_inx_q.pop_front();
                tg = exp_tag_q.pop_front();
                if (out_value !== ev || out_inexact !== ei) begin
                    n_fail++;
                    $display("FAIL %s: got %h inexact %b, expected %h inexact %b",
                             tg, out_value, out_inexact, ev, ei);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_fail++;
        $display("FAIL watchdog: run hung, actual running, expected finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        n_tests++;
        if (out_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R10 reset: out_valid %b, expected 0", out_valid);
        end
        rst_n = 1'b1;
        monitor_on = 1'b1;
        @(negedge clk);

        // R1 directions at M=0
        drive(32'h3FA66666, 8'h00, 2'b00, 32'h3F800000, 1'b1, "R1 1.3 nearest");
        drive(32'h40200000, 8'h02, 2'b00, 32'h40400000, 1'b1, "R1 2.5 up");
        drive(32'hC0200000, 8'h01, 2'b00, 32'hC0400000, 1'b1, "R1 -2.5 down");
        drive(32'hC0200000, 8'h03, 2'b00, 32'hC0000000, 1'b1, "R1 -2.5 toward zero");
        // R1 fraction counts
        drive(32'h3FA66666, 8'h10, 2'b00, 32'h3FC00000, 1'b1, "R1 1.3 M=1");
        drive(32'h3FA66666, 8'h20, 2'b00, 32'h3FA00000, 1'b1, "R1 1.3 M=2");
        drive(32'h3FA66666, 8'hF0, 2'b00, 32'h3FA66600, 1'b1, "R1 1.3 M=15");
        // R2 ties
        drive(32'h40200000, 8'h00, 2'b00, 32'h40000000, 1'b1, "R2 2.5 tie even");
        drive(32'h40600000, 8'h00, 2'b00, 32'h40800000, 1'b1, "R2 3.5 tie even");
        drive(32'h4AFFFFFF, 8'h00, 2'b00, 32'h4B000000, 1'b1, "R2 largest half tie");
        // R3 current mode
        drive(32'h40200000, 8'h04, 2'b10, 32'h40400000, 1'b1, "R3 cur up");
        drive(32'h40200000, 8'h07, 2'b00, 32'h40000000, 1'b1, "R3 field ignored");
        // R4 / R5
        drive(32'h3FA66666, 8'h08, 2'b00, 32'h3F800000, 1'b0, "R4 suppress");
        drive(32'h3F400000, 8'h20, 2'b00, 32'h3F400000, 1'b0, "R5 exact on grid");
        // R6
        drive(32'h501502F9, 8'h00, 2'b00, 32'h501502F9, 1'b0, "R6 large integer");
        // R7
        drive(32'h3E99999A, 8'h00, 2'b00, 32'h00000000, 1'b1, "R7 0.3 to +0");
        drive(32'hBE99999A, 8'h00, 2'b00, 32'h80000000, 1'b1, "R7 -0.3 to -0");
        drive(32'hBE99999A, 8'h02, 2'b00, 32'h80000000, 1'b1, "R7 -0.3 up to -0");
        drive(32'h3E99999A, 8'h02, 2'b00, 32'h3F800000, 1'b1, "R1 0.3 up");
        drive(32'h7F800000, 8'h00, 2'b00, 32'h7F800000, 1'b0, "R7 +inf");
        drive(32'hFF800000, 8'h31, 2'b00, 32'hFF800000, 1'b0, "R7 -inf");
        drive(32'h80000000, 8'h52, 2'b00, 32'h80000000, 1'b0, "R7 -zero");
        // R8
        drive(32'h7F800001, 8'h00, 2'b00, 32'h7FC00001, 1'b0, "R8 signalling NaN");
        drive(32'hFFC12345, 8'h02, 2'b00, 32'hFFC12345, 1'b0, "R8 quiet NaN");
        // R9
        drive(32'h00000001, 8'hF2, 2'b00, 32'h38000000, 1'b1, "R9 subnormal up");
        drive(32'h00000001, 8'hF0, 2'b00, 32'h00000000, 1'b1, "R9 subnormal nearest");
        drive(32'h3FFFFFFF, 8'hF0, 2'b00, 32'h40000000, 1'b1, "R9 carry to 2.0");
        idle_cycle();
        repeat (3) @(negedge clk);

        // R10: idle yields no valid
        n_tests++;
        if (out_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R10 drain: out_valid %b, expected 0", out_valid);
        end
        n_tests++;
        if (exp_val_q.size() != 0) begin
            n_fail++;
            $display("FAIL R10 count: %0d results missing, expected 0", exp_val_q.size());
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule